// File: doc/BRIEF.md
# Scripted Register Access Sequencer

This block walks a byte-coded command script held in a memory and turns each command into traffic on a simple register bus. The script can write registers, read them and throw the result away, or read them and compare the value with an expected value under a bit mask. A halt command ends the run. The block is used to bring a register-mapped block up in a fixed order and then confirm its status without a processor. Repeated plain reads of a status register fill time before a compare.

The sequencer has one control state machine with seven states. ST_OPCODE fetches an opcode byte. ST_ARGS fetches the operand bytes of the command, one byte per cycle. ST_WRITE issues the write strobe. ST_READ issues the read strobe. ST_SAMPLE captures the returned data and compares it if the command is a check. ST_HALT and ST_TRAP are terminal states.

The transitions are as follows:
- ST_OPCODE goes to ST_ARGS for a write, read or check opcode, to ST_HALT for the halt opcode, and to ST_TRAP for any other byte.
- ST_ARGS goes to ST_WRITE or ST_READ after the last operand byte of the command.
- ST_WRITE and ST_SAMPLE go back to ST_OPCODE.
- ST_READ always goes to ST_SAMPLE.
- ST_HALT and ST_TRAP hold until reset.

Top module: `reg_script_seq`

## Requirements
- R1: Opcode 0x01 is followed by a 16-bit address and 16-bit data, each sent high byte first. In the cycle after the last data byte is fetched, bus_wr is high for one cycle with that address on bus_addr and that data on bus_wdata. The opcode byte is fetched again in the next cycle, so the command takes 6 cycles.
- R2: Opcode 0x02 is followed by a 16-bit address, high byte first. bus_rd is high for one cycle right after the second address byte. The returned data does not change mismatch_cnt. The command takes 5 cycles.
- R3: Opcode 0x03 is followed by an address, an expected value and a mask, each 16 bits and sent high byte first. bus_rdata is sampled in the cycle after bus_rd. The check fails when (bus_rdata AND mask) differs from (expected AND mask). The command takes 9 cycles.
- R4: Each failed check raises mismatch_cnt by one, starting in the cycle after the sample cycle. The count stops at 255 and is never decremented except by reset.
- R5: Opcode 0xFF halts the block. From the next cycle on, done stays high and fetch_en, bus_wr and bus_rd stay low.
- R6: Any opcode other than 0x01, 0x02, 0x03 or 0xFF sets bad_op and done. After that the block fetches no more bytes and makes no bus access.
- R7: pass is high when done is high, bad_op is low and mismatch_cnt is zero. fail is high when done is high and mismatch_cnt is non-zero. pass and fail are never high together.
- R8: Commands run strictly in script order. Exactly one script byte is fetched in each ST_OPCODE or ST_ARGS cycle. fetch_addr advances by one after each fetch. bus_wr and bus_rd are never high together.
- R9: A synchronous active-high rst sets fetch_addr to 0 and clears done, pass, fail, bad_op and mismatch_cnt. The next opcode is then fetched from address 0.
- R10: fetch_data is taken in the same cycle that fetch_en and fetch_addr present its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | output | 1 | A script byte is consumed this cycle |
| fetch_addr | output | FETCH_AW | Script byte address |
| fetch_data | input | 8 | Script byte at fetch_addr, same cycle |
| bus_addr | output | BUS_AW | Register bus address |
| bus_wdata | output | BUS_DW | Register bus write data |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_rdata | input | BUS_DW | Read data, valid the cycle after bus_rd |
| done | output | 1 | Sequencer has stopped |
| pass | output | 1 | Stopped cleanly with no mismatch |
| fail | output | 1 | Stopped with at least one mismatch |
| bad_op | output | 1 | Stopped on an unknown opcode |
| mismatch_cnt | output | CNT_W | Saturating count of failed checks |

## Verification
The assertions check the following on every cycle:
- the strobes never overlap;
- fetch_addr steps by one per fetched byte;
- a read strobe is followed by a quiet sample cycle;
- done is sticky and silences fetch and bus activity;
- the mismatch counter only holds or rises by one and sticks at its maximum;
- pass and fail are exclusive;
- reset clears the outputs.

Only the bench scenarios can show the rest: the exact cycle of each strobe and the address and data it carries, the masked compare outcome against a register model, trapping on an unknown opcode partway through a script, saturation after more than 255 failures, and a restart from address zero after a reset in mid-script.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    localparam logic [7:0] OP_WRITE = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h02;
    localparam logic [7:0] OP_CHECK = 8'h03;
    localparam logic [7:0] OP_HALT  = 8'hFF;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ARGS,
        ST_WRITE,
        ST_READ,
        ST_SAMPLE,
        ST_HALT,
        ST_TRAP
    } seq_state_t;

    typedef enum logic [1:0] {
        K_WR,
        K_RD,
        K_CHK
    } cmd_kind_t;

endpackage

// File: rtl/seqr_fsm.sv
module seqr_fsm
    import seqr_pkg::*;
#(
    parameter int FETCH_AW = 12,
    parameter int N_WR     = 4,
    parameter int N_RD     = 2,
    parameter int N_CHK    = 6,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          fetch_data,
    output logic                fetch_en,
    output logic [FETCH_AW-1:0] fetch_addr,
    output logic                arg_we,
    output logic [IDX_W-1:0]    arg_idx,
    output logic                bus_wr,
    output logic                bus_rd,
    output logic                cmp_en,
    output logic                done,
    output logic                bad_op
);

    seq_state_t          state_q, state_d;
    cmd_kind_t           kind_q, kind_d;
    logic [IDX_W-1:0]    idx_q, idx_d;
    logic [IDX_W-1:0]    last_idx;
    logic [FETCH_AW-1:0] ptr_q;

    // index of the final operand byte for the current command
    always_comb begin
        unique case (kind_q)
            K_WR:    last_idx = IDX_W'(N_WR - 1);
            K_RD:    last_idx = IDX_W'(N_RD - 1);
            K_CHK:   last_idx = IDX_W'(N_CHK - 1);
            default: last_idx = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_OPCODE: begin
                idx_d = '0;
                unique case (fetch_data)
                    OP_WRITE: begin kind_d = K_WR;  state_d = ST_ARGS; end
                    OP_READ:  begin kind_d = K_RD;  state_d = ST_ARGS; end
                    OP_CHECK: begin kind_d = K_CHK; state_d = ST_ARGS; end
                    OP_HALT:  state_d = ST_HALT;
                    default:  state_d = ST_TRAP;
                endcase
            end
            ST_ARGS: begin
                idx_d = idx_q + 1'b1;
                if (idx_q == last_idx)
                    state_d = (kind_q == K_WR) ? ST_WRITE : ST_READ;
            end
            ST_WRITE:  state_d = ST_OPCODE;
            ST_READ:   state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = ST_OPCODE;
            ST_HALT:   state_d = ST_HALT;
            ST_TRAP:   state_d = ST_TRAP;
            default:   state_d = ST_TRAP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPCODE;
            kind_q  <= K_WR;
            idx_q   <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            idx_q   <= idx_d;
            if (fetch_en)
                ptr_q <= ptr_q + 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        fetch_en = 1'b0;
        arg_we   = 1'b0;
        bus_wr   = 1'b0;
        bus_rd   = 1'b0;
        cmp_en   = 1'b0;
        done     = 1'b0;
        bad_op   = 1'b0;
        unique case (state_q)
            ST_OPCODE: fetch_en = 1'b1;
            ST_ARGS:   begin fetch_en = 1'b1; arg_we = 1'b1; end
            ST_WRITE:  bus_wr = 1'b1;
            ST_READ:   bus_rd = 1'b1;
            ST_SAMPLE: cmp_en = (kind_q == K_CHK);
            ST_HALT:   done = 1'b1;
            ST_TRAP:   begin done = 1'b1; bad_op = 1'b1; end
            default:   begin done = 1'b1; bad_op = 1'b1; end
        endcase
    end

    assign fetch_addr = ptr_q;
    assign arg_idx    = idx_q;

endmodule

// File: rtl/seqr_args.sv
module seqr_args #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_in,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    data,
    output logic [DW-1:0]    mask
);

    localparam int AB = AW / 8;
    localparam int DB = DW / 8;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] fld_q [2];

    // address bytes occupy the first AB operand slots, high byte first
    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (we && (int'(idx) < AB))
            addr_q <= {addr_q[AW-9:0], byte_in};
    end

    // data/expected field then mask field, each DB bytes wide
    for (genvar f = 0; f < 2; f++) begin : g_fld
        localparam int LO = AB + f * DB;
        always_ff @(posedge clk) begin
            if (rst)
                fld_q[f] <= '0;
            else if (we && (int'(idx) >= LO) && (int'(idx) < LO + DB))
                fld_q[f] <= {fld_q[f][DW-9:0], byte_in};
        end
    end

    assign addr = addr_q;
    assign data = fld_q[0];
    assign mask = fld_q[1];

endmodule

// File: rtl/seqr_check.sv
module seqr_check #(
    parameter int DW    = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DW-1:0]    rdata,
    input  logic [DW-1:0]    expv,
    input  logic [DW-1:0]    mask,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             miss;
    logic [CNT_W-1:0] cnt_q;

    assign miss = |((rdata ^ expv) & mask);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (en && miss && (cnt_q != CNT_MAX))
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/reg_script_seq.sv
module reg_script_seq #(
    parameter int FETCH_AW = 12,
    parameter int BUS_AW   = 16,
    parameter int BUS_DW   = 16,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    output logic                fetch_en,
    output logic [FETCH_AW-1:0] fetch_addr,
    input  logic [7:0]          fetch_data,
    output logic [BUS_AW-1:0]   bus_addr,
    output logic [BUS_DW-1:0]   bus_wdata,
    output logic                bus_wr,
    output logic                bus_rd,
    input  logic [BUS_DW-1:0]   bus_rdata,
    output logic                done,
    output logic                pass,
    output logic                fail,
    output logic                bad_op,
    output logic [CNT_W-1:0]    mismatch_cnt
);

    localparam int AB    = BUS_AW / 8;
    localparam int DB    = BUS_DW / 8;
    localparam int N_WR  = AB + DB;
    localparam int N_RD  = AB;
    localparam int N_CHK = AB + 2 * DB;
    localparam int IDX_W = $clog2(N_CHK + 1);

    logic             arg_we;
    logic [IDX_W-1:0] arg_idx;
    logic             cmp_en;
    logic [BUS_DW-1:0] mask;

    seqr_fsm #(
        .FETCH_AW (FETCH_AW),
        .N_WR     (N_WR),
        .N_RD     (N_RD),
        .N_CHK    (N_CHK),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fetch_data (fetch_data),
        .fetch_en   (fetch_en),
        .fetch_addr (fetch_addr),
        .arg_we     (arg_we),
        .arg_idx    (arg_idx),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .cmp_en     (cmp_en),
        .done       (done),
        .bad_op     (bad_op)
    );

    seqr_args #(
        .AW    (BUS_AW),
        .DW    (BUS_DW),
        .IDX_W (IDX_W)
    ) u_args (
        .clk     (clk),
        .rst     (rst),
        .we      (arg_we),
        .idx     (arg_idx),
        .byte_in (fetch_data),
        .addr    (bus_addr),
        .data    (bus_wdata),
        .mask    (mask)
    );

    seqr_check #(
        .DW    (BUS_DW),
        .CNT_W (CNT_W)
    ) u_check (
        .clk   (clk),
        .rst   (rst),
        .en    (cmp_en),
        .rdata (bus_rdata),
        .expv  (bus_wdata),
        .mask  (mask),
        .cnt   (mismatch_cnt)
    );

    assign pass = done && !bad_op && (mismatch_cnt == '0);
    assign fail = done && (mismatch_cnt != '0);

endmodule

// File: rtl/seqr_sva.sv
module seqr_sva #(
    parameter int FETCH_AW = 12,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                fetch_en,
    input logic [FETCH_AW-1:0] fetch_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic                done,
    input logic                pass,
    input logic                fail,
    input logic [CNT_W-1:0]    mismatch_cnt
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    a_r8_fetch_step: assert property (@(posedge clk) disable iff (rst)
        fetch_en |=> fetch_addr == $past(fetch_addr) + 1'b1);

    a_r3_quiet_sample: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> (!bus_rd && !bus_wr && !fetch_en));

    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r5_silent_after_stop: assert property (@(posedge clk) disable iff (rst)
        done |-> (!fetch_en && !bus_wr && !bus_rd));

    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (mismatch_cnt != CMAX) |=> (mismatch_cnt == $past(mismatch_cnt) ||
                                    mismatch_cnt == $past(mismatch_cnt) + 1'b1));

    a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
        (mismatch_cnt == CMAX) |=> (mismatch_cnt == CMAX));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (fetch_addr == '0 && !done && mismatch_cnt == '0));

endmodule

bind reg_script_seq seqr_sva #(
    .FETCH_AW (FETCH_AW),
    .CNT_W    (CNT_W)
) u_sva (
    .clk          (clk),
    .rst          (rst),
    .fetch_en     (fetch_en),
    .fetch_addr   (fetch_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .done         (done),
    .pass         (pass),
    .fail         (fail),
    .mismatch_cnt (mismatch_cnt)
);

// File: tb/tb_reg_script_seq.sv
module tb_reg_script_seq;

    localparam int MAXC = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_en;
    logic [11:0] fetch_addr;
    logic [7:0]  fetch_data;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_wr, bus_rd, done, pass, fail, bad_op;
    logic [7:0]  mismatch_cnt;

    always #4 clk = ~clk;

    reg_script_seq dut (
        .clk(clk), .rst(rst), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .done(done),
        .pass(pass), .fail(fail), .bad_op(bad_op), .mismatch_cnt(mismatch_cnt)
    );

    // script memory, read combinationally
    logic [7:0] prog [0:MAXC-1];
    int         plen;
    assign fetch_data = prog[fetch_addr];

    // register target: 16 words, data returned the cycle after bus_rd
    logic [15:0] rf [0:15];
    logic [15:0] rdata_q = '0;
    logic        rf_clr = 1'b0;
    assign bus_rdata = rdata_q;
    always @(posedge clk) begin
        if (rf_clr) begin
            for (int i = 0; i < 16; i++) rf[i] <= '0;
        end else begin
            if (bus_wr) rf[bus_addr[3:0]] <= bus_wdata;
            if (bus_rd) rdata_q <= rf[bus_addr[3:0]];
        end
    end

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected per-cycle behaviour
    bit          e_fetch [0:MAXC-1];
    int          e_faddr [0:MAXC-1];
    bit          e_wr    [0:MAXC-1];
    bit          e_rd    [0:MAXC-1];
    bit          e_inc   [0:MAXC-1];
    logic [15:0] e_addr  [0:MAXC-1];
    logic [15:0] e_wdata [0:MAXC-1];
    int          done_c;
    bit          e_bad;

    task automatic clear_prog();
        for (int i = 0; i < MAXC; i++) prog[i] = 8'h00;
        plen = 0;
    endtask
    task automatic put(input logic [7:0] b);
        prog[plen] = b;
        plen++;
    endtask
    task automatic p_wr(input logic [15:0] a, input logic [15:0] d);
        put(8'h01); put(a[15:8]); put(a[7:0]); put(d[15:8]); put(d[7:0]);
    endtask
    task automatic p_rd(input logic [15:0] a);
        put(8'h02); put(a[15:8]); put(a[7:0]);
    endtask
    task automatic p_ck(input logic [15:0] a, input logic [15:0] e, input logic [15:0] m);
        put(8'h03); put(a[15:8]); put(a[7:0]);
        put(e[15:8]); put(e[7:0]); put(m[15:8]); put(m[7:0]);
    endtask

    // behavioural interpreter of the script (R1, R2, R3, R5, R6)
    task automatic build_model();
        logic [15:0] mr [16];
        logic [7:0]  b [6];
        logic [7:0]  op;
        logic [15:0] a, d, m;
        int c, p, n;
        for (int i = 0; i < MAXC; i++) begin
            e_fetch[i] = 0; e_faddr[i] = 0; e_wr[i] = 0; e_rd[i] = 0;
            e_inc[i] = 0; e_addr[i] = '0; e_wdata[i] = '0;
        end
        for (int i = 0; i < 16; i++) mr[i] = '0;
        for (int i = 0; i < 6; i++) b[i] = '0;
        c = 0; p = 0; done_c = -1; e_bad = 0;
        while (done_c < 0) begin
            e_fetch[c] = 1; e_faddr[c] = p; op = prog[p]; p++; c++;
            if (op == 8'h01 || op == 8'h02 || op == 8'h03) begin
                n = (op == 8'h01) ? 4 : (op == 8'h02) ? 2 : 6;
                for (int i = 0; i < n; i++) begin
                    e_fetch[c] = 1; e_faddr[c] = p; b[i] = prog[p]; p++; c++;
                end
                a = {b[0], b[1]}; d = {b[2], b[3]}; m = {b[4], b[5]};
                if (op == 8'h01) begin
                    e_wr[c] = 1; e_addr[c] = a; e_wdata[c] = d; mr[a[3:0]] = d; c++;
                end else begin
                    e_rd[c] = 1; e_addr[c] = a; c++;
                    if (op == 8'h03 && ((mr[a[3:0]] ^ d) & m) != 16'h0) e_inc[c] = 1;
                    c++;
                end
            end else begin
                done_c = c;
                e_bad = (op != 8'hFF);
            end
        end
    endtask

    // reset, then compare every cycle; limit >= 0 stops early
    task automatic run(input string name, input int limit);
        int last, cnt;
        build_model();
        rf_clr = 1'b1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(fetch_addr == 0 && !done && !pass && !fail && !bad_op && mismatch_cnt == 0,
            {name, " R9 reset state"},
            {fetch_addr, 3'b0, done, pass, fail, bad_op, mismatch_cnt}, 0);
        rf_clr = 1'b0;
        rst = 1'b0;
        last = (limit >= 0) ? limit : done_c + 5;
        cnt = 0;
        for (int c = 0; c <= last; c++) begin
            // R8 / R10: one byte per fetch cycle, address stepping in order
            chk(fetch_en == e_fetch[c], {name, " R8 fetch_en"}, fetch_en, e_fetch[c]);
            if (e_fetch[c])
                chk(fetch_addr == e_faddr[c], {name, " R10 fetch_addr"}, fetch_addr, e_faddr[c]);
            chk(bus_wr == e_wr[c], {name, " R1 bus_wr"}, bus_wr, e_wr[c]);
            chk(bus_rd == e_rd[c], {name, " R2 bus_rd"}, bus_rd, e_rd[c]);
            if (e_wr[c]) begin
                chk(bus_addr == e_addr[c], {name, " R1 write addr"}, bus_addr, e_addr[c]);
                chk(bus_wdata == e_wdata[c], {name, " R1 write data"}, bus_wdata, e_wdata[c]);
            end
            if (e_rd[c])
                chk(bus_addr == e_addr[c], {name, " R3 read addr"}, bus_addr, e_addr[c]);
            chk(mismatch_cnt == cnt, {name, " R4 mismatch_cnt"}, mismatch_cnt, cnt);
            chk(done == (c >= done_c), {name, " R5 done"}, done, (c >= done_c));
            if (e_inc[c] && cnt < 255) cnt++;
            @(negedge clk);
        end
        if (limit < 0) begin
            chk(bad_op == e_bad, {name, " R6 bad_op"}, bad_op, e_bad);
            chk(pass == (!e_bad && cnt == 0), {name, " R7 pass"}, pass, (!e_bad && cnt == 0));
            chk(fail == (cnt != 0), {name, " R7 fail"}, fail, (cnt != 0));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // mixed script: one failing check, masked-out difference passes (R3, R4, R7)
        clear_prog();
        p_wr(16'h0010, 16'h1234);
        p_wr(16'h0011, 16'hABCD);
        p_rd(16'h0010);
        p_rd(16'h0010);
        p_ck(16'h0010, 16'h1234, 16'hFFFF);
        p_ck(16'h0011, 16'hAB00, 16'hFF00);
        p_ck(16'h0011, 16'hABCE, 16'hFFFF);
        p_ck(16'h0010, 16'h1235, 16'hFFFE);
        put(8'hFF);
        run("mixed", -1);

        // clean script ending in pass; read data ignored (R2)
        clear_prog();
        p_wr(16'h0003, 16'h00FF);
        p_rd(16'h0003);
        p_ck(16'h0003, 16'h5A0F, 16'h000F);
        p_wr(16'h0004, 16'h8001);
        p_ck(16'h0004, 16'h8001, 16'hFFFF);
        put(8'hFF);
        run("clean", -1);

        // unknown opcode mid-script traps (R6)
        clear_prog();
        p_wr(16'h0001, 16'h0055);
        put(8'h20);
        p_wr(16'h0002, 16'h0066);
        put(8'hFF);
        run("trap", -1);

        // more than 255 failures saturate (R4)
        clear_prog();
        p_wr(16'h0007, 16'h0001);
        for (int i = 0; i < 260; i++) p_ck(16'h0007, 16'h0000, 16'h0001);
        put(8'hFF);
        run("partial", 60);
        // reset mid-script then rerun from address 0 (R9)
        run("saturate", -1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule